// File: doc/BRIEF.md
# Serial Data Byte Receiver

This block is the slave end of a serial link that carries an audio bitstream. A host supplies the serial clock, a data line and framing signals. The block samples the data on the chosen clock edge and groups the bits into bytes. Each finished byte goes to a downstream stream buffer as an 8-bit value with a strobe that lasts one system cycle. All serial pins are asynchronous to the system clock. Two-flop synchronizers bring them into the system domain, and edges are detected there. For that reason the system clock must run at least four times faster than the serial clock.

Three framing schemes can be chosen at run time. In select framing, an active-low data select encloses the bytes. The data select can come from its own pin, or it can be derived from the command chip select. In pulse framing, a sync signal marks the first bit of each byte. In gated framing, the sync signal is a window, and only bits sampled inside the window are taken. Configuration inputs also choose the sampling edge and the bit order.

Top module: `serial_byte_rx`

## Requirements
- R1: In select framing (cfgMode 2'b00, and also 2'b11), bits are taken only while the effective data select is low. When the select goes high, the bit counter returns to zero and a partial byte is dropped without a strobe.
- R2: With cfgShareSel=1, the effective data select is the inverse of cmdSelN, so bytes are received while cmdSelN is high. The dataSelN pin then has no effect.
- R3: In pulse framing (cfgMode 2'b01), the receiver waits while it is idle. The first sampling edge that finds byteSync high is taken as bit 0 of a byte.
- R4: In pulse framing, if byteSync is high at the eighth bit, the next eight bits form another byte without a new pulse. If byteSync is low there, the receiver goes idle.
- R5: In gated framing (cfgMode 2'b10), sampling edges that find byteSync low shift nothing and produce no byte.
- R6: In gated framing, a sampling edge that finds byteSync high after one that found it low restarts the byte at bit 0. Any partial byte is discarded.
- R7: cfgFallEdge=0 samples on rising edges of serClk, and cfgFallEdge=1 samples on falling edges.
- R8: With cfgLsbFirst=0, the first bit received becomes rxByte[7]. With cfgLsbFirst=1, it becomes rxByte[0].
- R9: Each completed byte raises rxValid for exactly one system cycle. rxValid rises two system cycles after the system edge that first registers the completing serial clock edge. rxByte changes only together with rxValid and holds its value until the next byte.
- R10: After reset, rxValid and rxByte are 0 and the bit counter is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| serClk | input | 1 | Serial bit clock from the host |
| serData | input | 1 | Serial data line |
| dataSelN | input | 1 | Active-low data select pin |
| cmdSelN | input | 1 | Command chip select, used when the shared-select option is on |
| byteSync | input | 1 | Byte sync or gating signal |
| cfgMode | input | 2 | Framing: 00 select, 01 pulse, 10 gated, 11 select |
| cfgFallEdge | input | 1 | 1 = sample on falling serial clock edge |
| cfgLsbFirst | input | 1 | 1 = first bit goes to bit 0 |
| cfgShareSel | input | 1 | 1 = data select derived from cmdSelN |
| rxByte | output | 8 | Last completed byte |
| rxValid | output | 1 | One-cycle strobe per completed byte |

## Verification
Pulse framing that runs from one byte into the next is the hardest case to reach, because it only happens when byteSync is still high at the eighth sampling edge. The bench holds byteSync high across the whole of the first byte and then lowers it for the second, so the receiver keeps going with no new pulse. Gated realignment needs a window that closes partway through a byte and opens again. The bench builds this from a four-bit window, a short gap and a full window, and it expects only the byte sent in the last window. A behavioural model, delayed by the synchronizer pipeline, is checked against the outputs on every cycle, and a queue of intended bytes is checked on every strobe.

// File: rtl/sbr_pkg.sv
package sbr_pkg;
  typedef enum logic [1:0] {
    MODE_SELECT = 2'b00,
    MODE_PULSE  = 2'b01,
    MODE_GATED  = 2'b10,
    MODE_RSVD   = 2'b11
  } frameMode_t;

  // strobes from control to datapath
  typedef struct packed {
    logic shift;   // take one bit
    logic clear;   // drop partial byte
    logic emit;    // this bit completes a byte
  } rxStrobe_t;
endpackage

// File: rtl/sbr_sync.sv
module sbr_sync #(
  parameter int W      = 5,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < STAGES; i++) stg[i] <= '0;
    end else begin
      stg[0] <= din;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  assign dout = stg[STAGES-1];
endmodule

// File: rtl/sbr_ctrl.sv
module sbr_ctrl
  import sbr_pkg::*;
#(
  parameter int BYTE_W = 8
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       sckS,
  input  logic       syncS,
  input  logic       dsNS,
  input  logic       csNS,
  input  logic [1:0] cfgMode,
  input  logic       cfgFallEdge,
  input  logic       cfgShareSel,
  output rxStrobe_t  strobe
);
  localparam int CNT_W = $clog2(BYTE_W);
  localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(BYTE_W - 1);
  localparam logic [CNT_W-1:0] ONE      = CNT_W'(1);

  frameMode_t     mode;
  logic           sckPrev;
  logic [CNT_W-1:0] bitCnt, cntNext;
  logic           busy, busyNext;
  logic           gatePrev, gateNext;
  logic           sampleEvt, selActive, lastBit;

  assign mode      = frameMode_t'(cfgMode);
  assign sampleEvt = cfgFallEdge ? (sckPrev & ~sckS) : (~sckPrev & sckS);
  assign selActive = cfgShareSel ? csNS : ~dsNS;
  assign lastBit   = (bitCnt == LAST_IDX);

  always_comb begin
    strobe   = '0;
    cntNext  = bitCnt;
    busyNext = busy;
    gateNext = gatePrev;
    case (mode)
      MODE_PULSE: begin
        if (sampleEvt && (busy || syncS)) begin
          strobe.shift = 1'b1;
          if (lastBit) begin
            strobe.emit = 1'b1;
            cntNext     = '0;
            busyNext    = syncS;
          end else begin
            cntNext  = bitCnt + ONE;
            busyNext = 1'b1;
          end
        end
      end
      MODE_GATED: begin
        if (sampleEvt) begin
          gateNext = syncS;
          if (syncS) begin
            strobe.shift = 1'b1;
            if (!gatePrev) begin
              cntNext = ONE;
            end else if (lastBit) begin
              strobe.emit = 1'b1;
              cntNext     = '0;
            end else begin
              cntNext = bitCnt + ONE;
            end
          end
        end
      end
      default: begin
        if (!selActive) begin
          strobe.clear = 1'b1;
          cntNext      = '0;
        end else if (sampleEvt) begin
          strobe.shift = 1'b1;
          if (lastBit) begin
            strobe.emit = 1'b1;
            cntNext     = '0;
          end else begin
            cntNext = bitCnt + ONE;
          end
        end
      end
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sckPrev  <= 1'b0;
      bitCnt   <= '0;
      busy     <= 1'b0;
      gatePrev <= 1'b0;
    end else begin
      sckPrev  <= sckS;
      bitCnt   <= cntNext;
      busy     <= busyNext;
      gatePrev <= gateNext;
    end
  end

  AST_SELECT_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    ((mode == MODE_SELECT) && !selActive) |=> (bitCnt == '0)); // R1
  AST_PULSE_STOP: assert property (@(posedge clk) disable iff (!rstN)
    ((mode == MODE_PULSE) && strobe.emit && !syncS) |=> !busy); // R4
  AST_GATE_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    ((mode == MODE_GATED) && sampleEvt && !syncS) |=> $stable(bitCnt)); // R5
  AST_GATE_REALIGN: assert property (@(posedge clk) disable iff (!rstN)
    ((mode == MODE_GATED) && sampleEvt && syncS && !gatePrev) |=> (bitCnt == ONE)); // R6
endmodule

// File: rtl/sbr_dp.sv
module sbr_dp
  import sbr_pkg::*;
#(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              dataS,
  input  logic              cfgLsbFirst,
  input  rxStrobe_t         strobe,
  output logic [BYTE_W-1:0] rxByte,
  output logic              rxValid
);
  logic [BYTE_W-1:0] shReg, shNext;

  assign shNext = cfgLsbFirst ? {dataS, shReg[BYTE_W-1:1]}
                              : {shReg[BYTE_W-2:0], dataS};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shReg   <= '0;
      rxByte  <= '0;
      rxValid <= 1'b0;
    end else begin
      if (strobe.clear)      shReg <= '0;
      else if (strobe.shift) shReg <= shNext;
      rxValid <= strobe.emit;
      if (strobe.emit) rxByte <= shNext;
    end
  end

  AST_VALID_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rstN)
    rxValid |=> !rxValid); // R9
  AST_BYTE_ONLY_ON_VALID: assert property (@(posedge clk) disable iff (!rstN)
    (rxByte != $past(rxByte)) |-> rxValid); // R9
  AST_EMIT_SHIFT: assert property (@(posedge clk) disable iff (!rstN)
    strobe.emit |=> rxValid); // R9
endmodule

// File: rtl/serial_byte_rx.sv
module serial_byte_rx
  import sbr_pkg::*;
#(
  parameter int BYTE_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              serClk,
  input  logic              serData,
  input  logic              dataSelN,
  input  logic              cmdSelN,
  input  logic              byteSync,
  input  logic [1:0]        cfgMode,
  input  logic              cfgFallEdge,
  input  logic              cfgLsbFirst,
  input  logic              cfgShareSel,
  output logic [BYTE_W-1:0] rxByte,
  output logic              rxValid
);
  localparam int PIN_W = 5;

  logic [PIN_W-1:0] pinRaw, pinSync;
  rxStrobe_t        strobe;

  assign pinRaw = {serClk, serData, dataSelN, cmdSelN, byteSync};

  sbr_sync #(.W(PIN_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rstN(rstN),
    .din (pinRaw),
    .dout(pinSync)
  );

  sbr_ctrl #(.BYTE_W(BYTE_W)) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .sckS       (pinSync[4]),
    .syncS      (pinSync[0]),
    .dsNS       (pinSync[2]),
    .csNS       (pinSync[1]),
    .cfgMode    (cfgMode),
    .cfgFallEdge(cfgFallEdge),
    .cfgShareSel(cfgShareSel),
    .strobe     (strobe)
  );

  sbr_dp #(.BYTE_W(BYTE_W)) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .dataS      (pinSync[3]),
    .cfgLsbFirst(cfgLsbFirst),
    .strobe     (strobe),
    .rxByte     (rxByte),
    .rxValid    (rxValid)
  );
endmodule

// File: tb/sim_serial_byte_rx.sv
module sim_serial_byte_rx;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic serClk = 1'b0, serData = 1'b0, dataSelN = 1'b1, cmdSelN = 1'b1, byteSync = 1'b0;
  logic [1:0] cfgMode = 2'b00;
  logic cfgFallEdge = 1'b0, cfgLsbFirst = 1'b0, cfgShareSel = 1'b0;
  logic [7:0] rxByte;
  logic rxValid;

  int compared = 0;
  int mismatched = 0;
  string curReq = "R10";
  bit finished = 0;

  // behavioural model state
  logic [4:0] p1 = '0, p2 = '0;
  logic p3 = 1'b0;
  int   mCnt = 0;
  bit   mBusy = 0, mGate = 0, mValid = 0;
  logic [7:0] mSh = '0, mByte = '0;
  logic [7:0] expQ[$];

  always #4 clk = ~clk;

  serial_byte_rx u0 (
    .clk(clk), .rstN(rstN), .serClk(serClk), .serData(serData),
    .dataSelN(dataSelN), .cmdSelN(cmdSelN), .byteSync(byteSync),
    .cfgMode(cfgMode), .cfgFallEdge(cfgFallEdge), .cfgLsbFirst(cfgLsbFirst),
    .cfgShareSel(cfgShareSel), .rxByte(rxByte), .rxValid(rxValid)
  );

  function automatic logic [7:0] shiftIn(logic [7:0] s, logic b);
    return cfgLsbFirst ? {b, s[7:1]} : {s[6:0], b};
  endfunction

  task automatic takeBit(logic b);
    mSh = shiftIn(mSh, b);
    if (mCnt == 7) begin
      mValid = 1; mByte = mSh; mCnt = 0;
    end else mCnt++;
  endtask

  // reference: synchronizer delay of two cycles plus edge history
  always @(posedge clk) begin
    logic [4:0] pNow, s;
    bit evt, sel;
    pNow = {serClk, serData, dataSelN, cmdSelN, byteSync};
    if (!rstN) begin
      p1 = '0; p2 = '0; p3 = 1'b0; mCnt = 0; mBusy = 0; mGate = 0;
      mValid = 0; mSh = '0; mByte = '0;
    end else begin
      s = p2;
      evt = cfgFallEdge ? (p3 && !s[4]) : (!p3 && s[4]);
      sel = cfgShareSel ? s[1] : !s[2];
      mValid = 0;
      if (cfgMode == 2'b01) begin
        if (evt && (mBusy || s[0])) begin
          if (mCnt == 7) begin takeBit(s[3]); mBusy = s[0]; end
          else begin takeBit(s[3]); mBusy = 1; end
        end
      end else if (cfgMode == 2'b10) begin
        if (evt) begin
          if (s[0]) begin
            if (!mGate) mCnt = 0;
            takeBit(s[3]);
          end
          mGate = s[0];
        end
      end else begin
        if (!sel) begin mCnt = 0; mSh = '0; end
        else if (evt) takeBit(s[3]);
      end
      p3 = p2[4]; p2 = p1; p1 = pNow;
    end
  end

  // comparison away from the active edge
  always @(negedge clk) begin
    if (!finished) begin
      compared++;
      if (rxValid !== mValid || rxByte !== mByte) begin
        mismatched++;
        $display("FAIL %s cycle compare: actual valid=%0b byte=%02h expected valid=%0b byte=%02h",
                 curReq, rxValid, rxByte, mValid, mByte);
      end
      if (rxValid === 1'b1) begin
        compared++;
        if (expQ.size() == 0) begin
          mismatched++;
          $display("FAIL %s unexpected byte: actual %02h expected none", curReq, rxByte);
        end else begin
          logic [7:0] e;
          e = expQ.pop_front();
          if (rxByte !== e) begin
            mismatched++;
            $display("FAIL %s byte: actual %02h expected %02h", curReq, rxByte, e);
          end
        end
      end
    end
  end

  task automatic bitOut(logic b, logic sy);
    serData = b; byteSync = sy;
    repeat (3) @(negedge clk);
    serClk = ~cfgFallEdge;
    repeat (3) @(negedge clk);
    serClk = cfgFallEdge;
  endtask

  task automatic sendByte(logic [7:0] v, logic [7:0] syMask);
    for (int k = 0; k < 8; k++)
      bitOut(cfgLsbFirst ? v[k] : v[7-k], syMask[k]);
  endtask

  task automatic settle();
    repeat (8) @(negedge clk);
  endtask

  task automatic queueEmpty();
    compared++;
    if (expQ.size() != 0) begin
      mismatched++;
      $display("FAIL %s missing bytes: actual %0d pending expected 0", curReq, expQ.size());
      expQ.delete();
    end
  endtask

  initial begin
    #(8 * 150000);
    if (!finished) begin
      mismatched++;
      $display("FAIL watchdog: actual timeout expected completion");
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    curReq = "R10";
    compared++;
    if (rxValid !== 1'b0 || rxByte !== 8'h00) begin
      mismatched++;
      $display("FAIL R10 reset: actual valid=%0b byte=%02h expected 0/00", rxValid, rxByte);
    end
    rstN = 1'b1;
    settle();

    // R1 R7 R8 R9: select framing, rising edge, msb first
    curReq = "R1";
    dataSelN = 1'b0;
    expQ.push_back(8'hA5); sendByte(8'hA5, 8'h00);
    expQ.push_back(8'h3C); sendByte(8'h3C, 8'h00);
    settle(); dataSelN = 1'b1; settle(); queueEmpty();

    // R1: partial byte dropped on deselect
    curReq = "R1";
    dataSelN = 1'b0;
    for (int k = 0; k < 5; k++) bitOut(1'b1, 1'b0);
    settle(); dataSelN = 1'b1; settle();
    dataSelN = 1'b0;
    expQ.push_back(8'h81); sendByte(8'h81, 8'h00);
    settle(); dataSelN = 1'b1; settle(); queueEmpty();

    // R8: lsb first
    curReq = "R8";
    cfgLsbFirst = 1'b1; dataSelN = 1'b0;
    expQ.push_back(8'h4E); sendByte(8'h4E, 8'h00);
    settle(); dataSelN = 1'b1; settle(); queueEmpty();
    cfgLsbFirst = 1'b0;

    // R7: falling edge sampling
    curReq = "R7";
    cfgFallEdge = 1'b1; serClk = 1'b1; settle();
    dataSelN = 1'b0;
    expQ.push_back(8'hD2); sendByte(8'hD2, 8'h00);
    settle(); dataSelN = 1'b1; settle(); queueEmpty();
    cfgFallEdge = 1'b0; serClk = 1'b0; settle();

    // R2: shared select, dataSelN pin ignored
    curReq = "R2";
    cfgShareSel = 1'b1; cmdSelN = 1'b0; dataSelN = 1'b0; settle();
    sendByte(8'hFF, 8'h00);
    settle(); queueEmpty();
    cmdSelN = 1'b1; dataSelN = 1'b1; settle();
    expQ.push_back(8'h6B); sendByte(8'h6B, 8'h00);
    settle(); cmdSelN = 1'b0; settle(); queueEmpty();
    cfgShareSel = 1'b0; cmdSelN = 1'b1; dataSelN = 1'b1; settle();

    // R3 R4: pulse framing
    curReq = "R3";
    cfgMode = 2'b01; settle();
    for (int k = 0; k < 3; k++) bitOut(1'b1, 1'b0);  // idle, no pulse
    expQ.push_back(8'h9A); sendByte(8'h9A, 8'h01);
    settle(); queueEmpty();
    curReq = "R4";
    expQ.push_back(8'hC3); sendByte(8'hC3, 8'hFF);   // sync high at 8th bit
    expQ.push_back(8'h17); sendByte(8'h17, 8'h00);   // continues without pulse
    for (int k = 0; k < 9; k++) bitOut(1'b1, 1'b0);  // idle again
    settle(); queueEmpty();

    // R5 R6: gated framing
    curReq = "R6";
    cfgMode = 2'b10; settle();
    for (int k = 0; k < 4; k++) bitOut(1'b1, 1'b1);
    curReq = "R5";
    for (int k = 0; k < 3; k++) bitOut(1'b0, 1'b0);
    curReq = "R6";
    expQ.push_back(8'h2D); sendByte(8'h2D, 8'hFF);
    bitOut(1'b0, 1'b0);
    settle(); queueEmpty();
    curReq = "R5";
    expQ.push_back(8'h5A); sendByte(8'h5A, 8'hFF);
    expQ.push_back(8'hE1); sendByte(8'hE1, 8'hFF);
    byteSync = 1'b0;
    settle(); queueEmpty();

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule